// File: doc/BRIEF.md
# Short Frame Assembler and Matcher

This block sits behind the bit decoder of a reader-to-tag receive path. Each decoded bit arrives with a one-cycle valid strobe. The block packs the bits, least significant first, into a frame register that carries its own length. A separate strobe marks the end of a frame. On that strobe the block decides whether the frame deserves an answer. If it does, the block raises a one-cycle response request that carries the reply word and the reply length, and a downstream serialiser sends them out.

Two kinds of frame are dropped at once. One is a frame of exactly six bits. The other is any frame of four bits or fewer, which counts as empty. Every other frame is compared against a fixed query table, and both the length and the value must agree for a match. The only table entry answers the 7-bit query 0x55 with the 6-bit reply 0x3B. A sticky matched flag records the result of the last frame that was compared. The frame register is cleared after every frame-end event.

Top module: `short_frame_matcher`

## Requirements
- R1: An accepted bit is written at the bit position equal to the current count, so the first bit of a frame lands in bit 0, and the count then rises by one. A 7-bit frame whose bits arrive in the order 1,0,1,0,1,0,1 therefore holds 0x55.
- R2: The frame holds at most 15 bits. A bit that arrives when the count is already 15 is discarded, and the count stays at 15.
- R3: A frame that ends with exactly 6 bits gives no response request, and the matched flag keeps its previous value.
- R4: A frame that ends with 4 or fewer bits gives no response request, and the matched flag keeps its previous value.
- R5: A frame that ends with 7 bits and value 0x55 raises `rsp_vld` in the cycle after the frame-end strobe. In that cycle `rsp_len` is 6 and `rsp_data` is 0x3B, and `matched` goes to 1.
- R6: A compared frame whose length or value differs from the table entry gives no response request and clears `matched` to 0. After reset, `matched` and `rsp_vld` are 0, and `rsp_len` and `rsp_data` are 0 whenever `rsp_vld` is low.
- R7: Every frame-end event clears the frame length and data, whether or not the frame was compared or matched.
- R8: `rsp_vld` is a pulse that lasts one cycle.
- R9: If a bit strobe and a frame-end strobe arrive in the same cycle, the old frame is evaluated without the bit, and that bit becomes bit 0 of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | A decoded bit is present this cycle |
| bit_val | input | 1 | Value of the decoded bit |
| frame_end | input | 1 | End-of-frame event |
| rsp_vld | output | 1 | One-cycle response request |
| rsp_len | output | 4 | Number of reply bits |
| rsp_data | output | 15 | Reply word, LSB sent first |
| matched | output | 1 | Result of the last compared frame |

## Verification
The assertions make no assumption about the inputs. Any mix of bit strobes and frame-end strobes is legal, including both in one cycle and frame-end strobes on back-to-back cycles, because those cases are part of the specified behaviour. The stimulus drives the inputs only on the falling clock edge and holds them stable across the rising edge. It sweeps every bit pattern for frame lengths 0 to 10, then adds directed overlong frames and coincident strobes, so the checker's internal length properties are exercised across the whole count range, including the saturated state.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  localparam int MAX_BITS  = 15;
  localparam int CNT_W     = $clog2(MAX_BITS + 1);
  localparam int N_ENTRIES = 1;
  localparam int SKIP_LEN  = 6;
  localparam int EMPTY_MAX = 4;

  typedef struct packed {
    logic [CNT_W-1:0]    len;
    logic [MAX_BITS-1:0] data;
  } frame_t;

  // query side of the lookup table
  function automatic frame_t query_entry(input int idx);
    frame_t f;
    f = '0;
    case (idx)
      0: begin f.len = CNT_W'(7); f.data = MAX_BITS'(16'h0055); end
      default: f = '0;
    endcase
    return f;
  endfunction

  // reply side of the lookup table
  function automatic frame_t reply_entry(input int idx);
    frame_t f;
    f = '0;
    case (idx)
      0: begin f.len = CNT_W'(6); f.data = MAX_BITS'(16'h003B); end
      default: f = '0;
    endcase
    return f;
  endfunction

  // frame is worth comparing: not empty and not the skipped length
  function automatic logic frame_evaluated(input frame_t f);
    return (int'(f.len) > EMPTY_MAX) && (int'(f.len) != SKIP_LEN);
  endfunction

  // place a bit at the position given by the current count
  function automatic logic [MAX_BITS-1:0] put_bit(input logic [MAX_BITS-1:0] d,
                                                  input logic [CNT_W-1:0] pos,
                                                  input logic b);
    logic [MAX_BITS-1:0] r;
    r = d;
    r[pos] = b;
    return r;
  endfunction

endpackage

// File: rtl/sfm_collector.sv
module sfm_collector
  import sfm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   bit_vld,
  input  logic   bit_val,
  input  logic   frame_end,
  output frame_t cur
);

  logic room;
  assign room = (int'(cur.len) < MAX_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (frame_end) begin
      // the coincident bit opens the next frame
      cur.len  <= bit_vld ? CNT_W'(1) : '0;
      cur.data <= bit_vld ? MAX_BITS'(bit_val) : '0;
    end else if (bit_vld && room) begin
      cur.data <= put_bit(cur.data, cur.len, bit_val);
      cur.len  <= cur.len + CNT_W'(1);
    end
  end

endmodule

// File: rtl/sfm_lookup.sv
module sfm_lookup
  import sfm_pkg::*;
(
  input  frame_t frame,
  output logic   hit,
  output frame_t reply
);

  logic [N_ENTRIES-1:0] entry_hit;

  generate
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
      frame_t q;
      assign q = query_entry(g);
      assign entry_hit[g] = (frame.len == q.len) && (frame.data == q.data);
    end
  endgenerate

  // lowest index wins
  always_comb begin
    hit   = 1'b0;
    reply = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (entry_hit[i]) begin
        hit   = 1'b1;
        reply = reply_entry(i);
      end
    end
  end

endmodule

// File: rtl/short_frame_matcher.sv
module short_frame_matcher
  import sfm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_vld,
  input  logic                bit_val,
  input  logic                frame_end,
  output logic                rsp_vld,
  output logic [CNT_W-1:0]    rsp_len,
  output logic [MAX_BITS-1:0] rsp_data,
  output logic                matched
);

  frame_t cur_frame;
  frame_t lut_reply;
  logic   lut_hit;
  logic   eval_now;
  logic   answer_now;

  sfm_collector u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_val   (bit_val),
    .frame_end (frame_end),
    .cur       (cur_frame)
  );

  sfm_lookup u_lookup (
    .frame (cur_frame),
    .hit   (lut_hit),
    .reply (lut_reply)
  );

  assign eval_now   = frame_end && frame_evaluated(cur_frame);
  assign answer_now = eval_now && lut_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_len  <= '0;
      rsp_data <= '0;
      matched  <= 1'b0;
    end else begin
      rsp_vld  <= answer_now;
      rsp_len  <= answer_now ? lut_reply.len  : '0;
      rsp_data <= answer_now ? lut_reply.data : '0;
      if (eval_now) matched <= lut_hit;
    end
  end

endmodule

// File: rtl/sfm_checker.sv
module sfm_checker
  import sfm_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                bit_vld,
  input logic                frame_end,
  input logic [CNT_W-1:0]    cnt,
  input logic                rsp_vld,
  input logic [CNT_W-1:0]    rsp_len,
  input logic [MAX_BITS-1:0] rsp_data,
  input logic                matched
);

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld && !frame_end && int'(cnt) < MAX_BITS) |=> cnt == $past(cnt) + CNT_W'(1));

  a_r2_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) == MAX_BITS && !frame_end) |=> int'(cnt) == MAX_BITS);

  a_r3_skip_six: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && int'(cnt) == SKIP_LEN) |=> (!rsp_vld && $stable(matched)));

  a_r4_skip_short: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && int'(cnt) <= EMPTY_MAX) |=> (!rsp_vld && $stable(matched)));

  a_r5_reply_word: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> (int'(rsp_len) == 6 && rsp_data == MAX_BITS'(16'h003B) && matched));

  a_r6_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_vld |-> (rsp_len == '0 && rsp_data == '0));

  a_r7_clear_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> cnt == CNT_W'($past(bit_vld)));

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |=> !rsp_vld);

endmodule

bind short_frame_matcher sfm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_vld   (bit_vld),
  .frame_end (frame_end),
  .cnt       (cur_frame.len),
  .rsp_vld   (rsp_vld),
  .rsp_len   (rsp_len),
  .rsp_data  (rsp_data),
  .matched   (matched)
);

// File: tb/short_frame_matcher_tb.sv
module short_frame_matcher_tb;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_vld = 1'b0;
  logic        bit_val = 1'b0;
  logic        frame_end = 1'b0;
  logic        rsp_vld;
  logic [3:0]  rsp_len;
  logic [14:0] rsp_data;
  logic        matched;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit exp_m = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  short_frame_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .frame_end(frame_end), .rsp_vld(rsp_vld), .rsp_len(rsp_len),
    .rsp_data(rsp_data), .matched(matched)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // feed bits LSB first, one per cycle
  task automatic push_bits(input int n, input int v);
    for (int i = 0; i < n; i++) begin
      bit_vld = 1'b1;
      bit_val = v[i];
      @(negedge clk);
    end
    bit_vld = 1'b0;
  endtask

  // close the frame and check the reply; n is the count kept by the frame
  task automatic close_and_check(input string req, input int n, input int v);
    bit evaluated;
    bit hit;
    evaluated = (n > 4) && (n != 6);
    hit = evaluated && (n == 7) && ((v & 16'h7FFF) == 16'h55);
    if (evaluated) exp_m = hit;
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    chk({req, " rsp_vld"}, int'(rsp_vld), int'(hit));
    chk({req, " rsp_len"}, int'(rsp_len), hit ? 6 : 0);
    chk({req, " rsp_data"}, int'(rsp_data), hit ? 59 : 0);
    chk({req, " matched"}, int'(matched), int'(exp_m));
    @(negedge clk);
    chk("R8 pulse ends", int'(rsp_vld), 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    chk("R6 reset rsp_vld", int'(rsp_vld), 0);
    chk("R6 reset matched", int'(matched), 0);
    chk("R6 reset rsp_len", int'(rsp_len), 0);
    chk("R6 reset rsp_data", int'(rsp_data), 0);

    // R5 basic match
    push_bits(7, 'h55);
    close_and_check("R5 match", 7, 'h55);
    // R3 six-bit frame after a match keeps matched
    push_bits(6, 'h15);
    close_and_check("R3 six bits", 6, 'h15);
    // R4 short frame keeps matched
    push_bits(3, 'h5);
    close_and_check("R4 short", 3, 'h5);
    // R6 near miss clears matched
    push_bits(7, 'h54);
    close_and_check("R6 miss value", 7, 'h54);
    push_bits(8, 'h55);
    close_and_check("R6 miss length", 8, 'h55);
    // R7 leftover bits of an ignored frame must not leak into the next
    push_bits(2, 'h1);
    close_and_check("R7 ignored", 2, 'h1);
    push_bits(7, 'h55);
    close_and_check("R7 clear then match", 7, 'h55);
    // R2 overlong frame saturates at 15 bits
    push_bits(20, 'h55);
    close_and_check("R2 overlong", 15, 'h55);
    push_bits(7, 'h55);
    close_and_check("R2 next frame", 7, 'h55);

    // R9 coincident bit and frame end
    push_bits(6, 'h15);
    bit_vld = 1'b1;
    bit_val = 1'b1;
    frame_end = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
    frame_end = 1'b0;
    chk("R9 old frame skipped", int'(rsp_vld), 0);
    push_bits(6, 'h2A);
    close_and_check("R9 bit starts next frame", 7, 'h55);

    // R1 exhaustive sweep of lengths 0..10
    for (int n = 0; n <= 10; n++) begin
      for (int v = 0; v < (1 << n); v++) begin
        push_bits(n, v);
        close_and_check("R1 sweep", n, v);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule